// File: doc/BRIEF.md
# Protected Register Write Guard

This block sits on a simple single-cycle peripheral bus and shields a small bank of protected control registers, such as a byte-wide clock control register, from accidental writes. Software unlocks a protected register by first writing any value to a command address. The very next bus write must then target a protected register. That write is committed, and the unlock is used up.

If any other bus write comes between the command write and the protected write, the unlock is cancelled and the protected write that follows is dropped. A handler that runs in that gap is the usual cause. A protected write with no unlock before it is also dropped. Every rejected sequence sets a sticky error bit in a status register, and software clears that bit explicitly.

Reads are never restricted. A read neither cancels nor uses up a pending unlock.

Top module: `prot_wr_guard`

## Requirements
- R1: A bus write to the command address (default 0x00) arms the unlock whatever the data value. The data is not stored, and a read of the command address returns 0.
- R2: While armed, a write to protected register i (address PROT_BASE+i, default 0x10 and 0x11) commits the written byte. The arming is consumed, so a second protected write that follows at once is dropped.
- R3: A write to a protected register while not armed leaves that register unchanged and sets the error bit.
- R4: While armed, a write to any address other than the command address or a protected register cancels the arming and sets the error bit. This includes the status address and unmapped addresses. A protected write after it is dropped. When a status write clears the error bit in the same cycle that it cancels an armed unlock, the error bit ends set.
- R5: The status register (default address 0x04) reads the error bit in bit 0, and all its other bits read 0.
- R6: The error bit is sticky. Only a status write with bit 0 equal to 0 clears it. A status write with bit 0 equal to 1 leaves it unchanged.
- R7: Reads of the protected registers need no unlock and return their current value. Reads of unmapped addresses return 0.
- R8: Read accesses while armed neither cancel nor consume the arming.
- R9: Active-low reset clears the arming and the error bit and loads the protected registers with their reset values (default 0x03 for register 0 and 0x00 for register 1).
- R10: A further command write while armed keeps the block armed and does not set the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from addr_i |

## Verification
On every cycle, the assertions check the following:
- a command write leaves the block armed;
- a protected write while armed consumes the arming;
- an unarmed protected write leaves the register bank unchanged;
- an intervening write both cancels the arming and raises the error;
- the error bit only falls on a clearing status write;
- reads and repeated command writes keep the arming.

Only the bench's sequences show the values that are actually committed or held, the read-back of the status and unmapped addresses, and the reset values loaded in the middle of a run.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;
  typedef enum logic [1:0] {
    ACC_CMD   = 2'd0,
    ACC_STAT  = 2'd1,
    ACC_PROT  = 2'd2,
    ACC_OTHER = 2'd3
  } acc_e;
endpackage

// File: rtl/pg_addr_decode.sv
module pg_addr_decode
  import prot_guard_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                NUM_PROT  = 2,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h00,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h04,
  parameter logic [ADDR_W-1:0] PROT_BASE = 'h10
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output acc_e                kind_o,
  output logic [NUM_PROT-1:0] sel_o
);
  for (genvar i = 0; i < NUM_PROT; i++) begin : g_sel
    localparam logic [ADDR_W-1:0] RegAddr = PROT_BASE + ADDR_W'(i);
    assign sel_o[i] = (addr_i == RegAddr);
  end

  always_comb begin
    if (addr_i == CMD_ADDR)       kind_o = ACC_CMD;
    else if (addr_i == STAT_ADDR) kind_o = ACC_STAT;
    else if (|sel_o)              kind_o = ACC_PROT;
    else                          kind_o = ACC_OTHER;
  end
endmodule

// File: rtl/pg_arm_ctrl.sv
module pg_arm_ctrl
  import prot_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic rd_i,
  input  acc_e kind_i,
  input  logic clr_bit_i,
  output logic commit_o,
  output logic armed_o,
  output logic err_o
);
  logic armed_q, err_q;
  logic err_set, err_clr;

  assign commit_o = wr_i && (kind_i == ACC_PROT) && armed_q;

  // unarmed protected write, or any non-command non-protected write while armed
  assign err_set = wr_i && (((kind_i == ACC_PROT) && !armed_q) ||
                            (armed_q && (kind_i == ACC_STAT || kind_i == ACC_OTHER)));
  assign err_clr = wr_i && (kind_i == ACC_STAT) && !clr_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (wr_i) armed_q <= (kind_i == ACC_CMD);
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign armed_o = armed_q;
  assign err_o   = err_q;

  AST_CMD_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == ACC_CMD) |=> armed_q); // R1
  AST_COMMIT_CONSUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && wr_i && kind_i == ACC_PROT) |=> !armed_q); // R2
  AST_INTERVENE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && wr_i && (kind_i == ACC_STAT || kind_i == ACC_OTHER)) |=> (!armed_q && err_q)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(wr_i && kind_i == ACC_STAT && !clr_bit_i)) |=> err_q); // R6
  AST_READ_KEEPS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && rd_i) |=> armed_q); // R8
  AST_REARM_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && wr_i && kind_i == ACC_CMD) |=> (armed_q && err_q == $past(err_q))); // R10
endmodule

// File: rtl/pg_prot_bank.sv
module pg_prot_bank #(
  parameter int                       DATA_W   = 8,
  parameter int                       NUM_PROT = 2,
  parameter logic [NUM_PROT*DATA_W-1:0] PROT_RST = '0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             commit_i,
  input  logic [NUM_PROT-1:0]              sel_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_PROT-1:0][DATA_W-1:0]  q_o
);
  for (genvar i = 0; i < NUM_PROT; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q_o[i] <= PROT_RST[i*DATA_W +: DATA_W];
      else if (commit_i && sel_i[i]) q_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/prot_wr_guard.sv
module prot_wr_guard
  import prot_guard_pkg::*;
#(
  parameter int                         ADDR_W    = 8,
  parameter int                         DATA_W    = 8,
  parameter int                         NUM_PROT  = 2,
  parameter logic [ADDR_W-1:0]          CMD_ADDR  = 'h00,
  parameter logic [ADDR_W-1:0]          STAT_ADDR = 'h04,
  parameter logic [ADDR_W-1:0]          PROT_BASE = 'h10,
  parameter logic [NUM_PROT*DATA_W-1:0] PROT_RST  = 16'h0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  acc_e                            kind;
  logic [NUM_PROT-1:0]             sel;
  logic                            wr, rd, commit, armed, err;
  logic [NUM_PROT-1:0][DATA_W-1:0] prot_q;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  pg_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT),
    .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR), .PROT_BASE(PROT_BASE)
  ) u_dec (
    .addr_i(addr_i), .kind_o(kind), .sel_o(sel)
  );

  pg_arm_ctrl u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .rd_i(rd), .kind_i(kind),
    .clr_bit_i(wdata_i[0]), .commit_o(commit), .armed_o(armed), .err_o(err)
  );

  pg_prot_bank #(
    .DATA_W(DATA_W), .NUM_PROT(NUM_PROT), .PROT_RST(PROT_RST)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit), .sel_i(sel),
    .wdata_i(wdata_i), .q_o(prot_q)
  );

  always_comb begin
    rdata_o = '0;
    if (kind == ACC_STAT) rdata_o = {{(DATA_W-1){1'b0}}, err};
    for (int i = 0; i < NUM_PROT; i++) begin
      if (sel[i]) rdata_o = prot_q[i];
    end
  end

  AST_UNARMED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && kind == ACC_PROT && !armed) |=> ($stable(prot_q) && err)); // R3
  AST_OTHER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && kind != ACC_PROT) |=> $stable(prot_q)); // R1
endmodule

// File: tb/tb_prot_wr_guard.sv
`timescale 1ns/1ps
module tb_prot_wr_guard;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic [7:0] rdata_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk_i = ~clk_i;

  prot_wr_guard dut (.*);

  typedef struct packed {
    logic       rd;
    logic [7:0] addr;
    logic [7:0] data;   // write data, or expected read data
    logic [7:0] req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h10, 8'h03, 8'd9},   // R9 reg0 reset value
    '{1'b1, 8'h11, 8'h00, 8'd9},   // R9 reg1 reset value
    '{1'b1, 8'h04, 8'h00, 8'd9},   // R9 error clear after reset
    '{1'b0, 8'h00, 8'hA5, 8'd1},   // arm
    '{1'b1, 8'h00, 8'h00, 8'd1},   // R1 command data not stored
    '{1'b1, 8'h10, 8'h03, 8'd8},   // R8 read while armed
    '{1'b0, 8'h10, 8'h07, 8'd2},   // commit
    '{1'b1, 8'h10, 8'h07, 8'd2},   // R2 committed
    '{1'b1, 8'h04, 8'h00, 8'd2},   // R2 no error
    '{1'b0, 8'h10, 8'h55, 8'd3},   // unarmed write
    '{1'b1, 8'h10, 8'h07, 8'd3},   // R3 dropped
    '{1'b1, 8'h04, 8'h01, 8'd3},   // R3 error set
    '{1'b0, 8'h04, 8'hFF, 8'd6},   // write 1: no effect
    '{1'b1, 8'h04, 8'h01, 8'd6},   // R6 still set
    '{1'b0, 8'h04, 8'h00, 8'd6},   // clear
    '{1'b1, 8'h04, 8'h00, 8'd5},   // R5 cleared, upper bits 0
    '{1'b0, 8'h00, 8'h00, 8'd4},   // arm
    '{1'b0, 8'h20, 8'h12, 8'd4},   // intervening unmapped write
    '{1'b1, 8'h04, 8'h01, 8'd4},   // R4 error set
    '{1'b0, 8'h11, 8'h99, 8'd4},   // protected write after cancel
    '{1'b1, 8'h11, 8'h00, 8'd4},   // R4 dropped
    '{1'b0, 8'h04, 8'h00, 8'd6},   // clear
    '{1'b0, 8'h00, 8'h00, 8'd10},  // arm
    '{1'b0, 8'h00, 8'h11, 8'd10},  // re-arm
    '{1'b1, 8'h04, 8'h00, 8'd10},  // R10 no error
    '{1'b0, 8'h11, 8'h3C, 8'd10},  // commit
    '{1'b1, 8'h11, 8'h3C, 8'd10},  // R10 still armed, committed
    '{1'b1, 8'h20, 8'h00, 8'd7},   // R7 unmapped read
    '{1'b0, 8'h00, 8'h00, 8'd4},   // arm
    '{1'b0, 8'h04, 8'h00, 8'd4},   // status clear-write intervenes
    '{1'b1, 8'h04, 8'h01, 8'd4},   // R4 set wins over clear
    '{1'b0, 8'h10, 8'hAA, 8'd4},   // protected write after cancel
    '{1'b1, 8'h10, 8'h07, 8'd4},   // R4 dropped
    '{1'b0, 8'h04, 8'h00, 8'd6}    // clear
  };

  task automatic check(input logic [7:0] exp, input string tag);
    n_chk++;
    if (rdata_o !== exp) begin
      n_fail++;
      $display("FAIL %s addr %h: got %h exp %h", tag, addr_i, rdata_o, exp);
    end
  endtask

  task automatic op(input logic rd, input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk_i);
    req_i = 1'b1; we_i = !rd; addr_i = a; wdata_i = rd ? 8'h00 : d;
    if (rd) begin
      #2;
      check(d, tag);
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++)
      op(VECS[i].rd, VECS[i].addr, VECS[i].data, $sformatf("R%0d vec%0d", VECS[i].req, i));
    idle();
    // directed: commit, then error, then reset mid-run
    op(1'b0, 8'h00, 8'h00, "R2");
    op(1'b0, 8'h10, 8'h5A, "R2");
    op(1'b1, 8'h10, 8'h5A, "R2 commit 0x5A");
    op(1'b0, 8'h10, 8'h66, "R2");
    op(1'b1, 8'h10, 8'h5A, "R2 second write dropped");
    op(1'b0, 8'h00, 8'h00, "R9"); // armed before reset
    idle();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = 1'b1; we_i = 1'b0; addr_i = 8'h10;
    #2 check(8'h03, "R9 reset reload");
    @(negedge clk_i);
    rst_ni = 1'b1;
    op(1'b1, 8'h04, 8'h00, "R9 error cleared");
    op(1'b0, 8'h10, 8'h77, "R9");
    op(1'b1, 8'h10, 8'h03, "R9 disarmed by reset");
    op(1'b1, 8'h04, 8'h01, "R3 unarmed error");
    idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule